// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block is a write-only serial programming port for a radio synthesizer and its modulation path. A host drives three wires: a bit clock, a data line and an active-low enable. The block samples all three on a fast system clock. While enable is low, each rising edge of the bit clock shifts one data bit into a shift register, most significant bit first. When enable returns high, the transfer is committed. The last bit received is an address bit, and it selects which of two parallel control words takes the shifted bits.

The two words are decoded into named control fields:
- a feedback divider made of a main counter ratio, a swallow count and their total;
- the transmit power level, both as a code and in dBm;
- the filter and compensation enables and their gain percentages;
- the VCO pretune and demodulator trim codes;
- the charge-pump current scale and its percentage;
- the test-mode selector and the flag it implies for charge-pump high impedance.

Each word update comes with a one-cycle load strobe. There is no bit counter. Surplus leading bits fall off the top of the shift register. A short transfer commits whatever the register then holds. The bus inputs pass through two-flop synchronisers, so the system clock must run at least four times faster than the bus clock. There is no data stream here, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `ser_ctl_port`

## Requirements
- R1: A data bit is shifted in only on a synchronised rising edge of `bus_clk` while `bus_en_n` is low. Clock edges seen while enable is high leave the shift register unchanged.
- R2: On the rising edge of `bus_en_n`, bit 0 of the shift register (the last bit received) selects the target word. With 1, word A takes shift bits [23:1]. With 0, word B takes shift bits [11:1]. The other word keeps its value.
- R3: The shift register is 24 bits wide. In a transfer longer than 24 bits, the earliest bits are discarded and only the last 24 count.
- R4: Word A fields, from MSB (bit 22) down to bit 0:
  - main code [22:19]
  - swallow [18:14], with bit 14 as its LSB
  - phase select [13]
  - power code [12:11]
  - filter enable [10]
  - compensation enable [9]
  - filter gain code [8:6]
  - pretune [5:2]
  - charge-pump code [1:0]
- R5: Word B fields: demodulator trim [10:6], compensation gain code [5:3], test select [2:0].
- R6: `main_ratio` is 64 plus the main code, giving a range of 64 to 79. `div_total` is 32 × `main_ratio` + swallow.
- R7: Charge-pump code mapping to `cp_pct`: 2 gives 80, 3 gives 90, 0 gives 100, 1 gives 110. Power code mapping to `pa_dbm`: 0 gives −17, 1 gives −7, 2 gives −1, 3 gives +3.
- R8: `gf_gain_pct` and `mcc_gain_pct` equal 60 plus 10 times their 3-bit code, giving a range of 60 to 130.
- R9: `cp_hiz` is 1 exactly when the test select is 4, 5 or 6.
- R10: After reset, word A holds:
  - main code 12
  - swallow 19
  - phase 1
  - power code 3
  - filter enable 1 and compensation enable 1
  - filter gain code 4
  - pretune 8
  - charge-pump code 0

  Word B holds demodulator trim 16, compensation gain code 4 and test select 0. Both strobes are low.
- R11: Each commit raises exactly one of `w1_load` and `w2_load`, for exactly one system cycle.
- R12: The number of bits in a transfer is not checked. A transfer shorter than 24 bits still commits. The new bits take the low positions, and the earlier contents of the shift register move up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4× the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Serial bit clock (asynchronous) |
| bus_dat | input | 1 | Serial data (asynchronous) |
| bus_en_n | input | 1 | Active-low transfer enable (asynchronous) |
| main_ratio | output | 7 | Main counter ratio, 64..79 |
| swallow | output | 5 | Swallow count |
| div_total | output | 12 | Total divide ratio |
| phase_norm | output | 1 | Compensation phase select, 1 = normal |
| pa_code | output | 2 | Transmit power code |
| pa_dbm | output | 6 | Transmit power in dBm, signed |
| gf_en | output | 1 | Gaussian filter enable |
| mcc_en | output | 1 | Modulation compensation enable |
| gf_gain_pct | output | 8 | Filter current scale in percent |
| vco_trim | output | 4 | VCO pretune code |
| cp_code | output | 2 | Charge-pump scale code |
| cp_pct | output | 8 | Charge-pump current in percent |
| demod_trim | output | 5 | Demodulator tuning code |
| mcc_gain_pct | output | 8 | Compensation current scale in percent |
| test_sel | output | 3 | Test mode select |
| cp_hiz | output | 1 | Charge pump held high impedance by test mode |
| w1_load | output | 1 | One-cycle strobe on word A update |
| w2_load | output | 1 | One-cycle strobe on word B update |

## Verification
The shift register itself has no port. A wrong shift or a missed edge therefore shows up only after the next enable rise. Within a few system cycles of that rise, a field is misplaced, the wrong word moves, or the wrong strobe fires. A re-commit with no clocks in between exposes any shift taken while enable was high: the word reloads with altered bits instead of its previous value. Faults in the decoded fields show at once as combinational errors against the word contents.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

  localparam int SR_W    = 24;
  localparam int WA_BITS = 23;
  localparam int WB_BITS = 11;

  typedef struct packed {
    logic [3:0] mc;
    logic [4:0] sc;
    logic       ps;
    logic [1:0] pa;
    logic       gf_en;
    logic       mcc_en;
    logic [2:0] gf_gain;
    logic [3:0] vco;
    logic [1:0] cp;
  } word_a_t;

  typedef struct packed {
    logic [4:0] demod;
    logic [2:0] mcc_gain;
    logic [2:0] test;
  } word_b_t;

  localparam word_a_t WA_RST = '{mc: 4'd12, sc: 5'd19, ps: 1'b1, pa: 2'd3,
                                 gf_en: 1'b1, mcc_en: 1'b1, gf_gain: 3'd4,
                                 vco: 4'd8, cp: 2'd0};
  localparam word_b_t WB_RST = '{demod: 5'd16, mcc_gain: 3'd4, test: 3'd0};

  function automatic logic [7:0] gain_pct(input logic [2:0] code);
    return 8'd60 + 8'd10 * {5'd0, code};
  endfunction

  function automatic logic [7:0] cp_pct_of(input logic [1:0] code);
    logic [7:0] r;
    unique case (code)
      2'd2:    r = 8'd80;
      2'd3:    r = 8'd90;
      2'd0:    r = 8'd100;
      default: r = 8'd110;
    endcase
    return r;
  endfunction

  function automatic logic signed [5:0] pa_dbm_of(input logic [1:0] code);
    logic signed [5:0] r;
    unique case (code)
      2'd0:    r = -6'sd17;
      2'd1:    r = -6'sd7;
      2'd2:    r = -6'sd1;
      default: r = 6'sd3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int           N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {2{RST_VAL[g]}};
      else        ff <= {ff[0], d[g]};
    end
    assign q[g] = ff[1];
  end

endmodule

// File: rtl/ser_ctl_shifter.sv
module ser_ctl_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_clk,
  input  logic         s_dat,
  input  logic         s_en_n,
  output logic [W-1:0] sreg,
  output logic         commit
);

  logic clk_d, en_d;
  logic clk_rise, shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      en_d  <= 1'b1;
    end else begin
      clk_d <= s_clk;
      en_d  <= s_en_n;
    end
  end

  assign clk_rise = s_clk & ~clk_d;
  assign shift_en = clk_rise & ~s_en_n;
  assign commit   = s_en_n & ~en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg <= '0;
    else if (shift_en) sreg <= {sreg[W-2:0], s_dat};
  end

  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_clk || clk_d || s_en_n) |=> $stable(sreg)); // R1

  AST_NO_SHIFT_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> $stable(sreg)); // R1

endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
  import ser_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [SR_W-1:0] sreg,
  output word_a_t         wa,
  output word_b_t         wb,
  output logic            wa_ld,
  output logic            wb_ld
);

  logic addr;
  assign addr = sreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa    <= WA_RST;
      wb    <= WB_RST;
      wa_ld <= 1'b0;
      wb_ld <= 1'b0;
    end else begin
      wa_ld <= commit & addr;
      wb_ld <= commit & ~addr;
      if (commit) begin
        if (addr) wa <= word_a_t'(sreg[WA_BITS:1]);
        else      wb <= word_b_t'(sreg[WB_BITS:1]);
      end
    end
  end

  AST_WA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wa) |-> wa_ld); // R2

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wb) |-> wb_ld); // R2

  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wa_ld, wb_ld}) <= 1); // R11

  AST_LOAD_PULSE_A: assert property (@(posedge clk) disable iff (!rst_n)
    wa_ld |=> !wa_ld); // R11

  AST_LOAD_PULSE_B: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ld |=> !wb_ld); // R11

endmodule

// File: rtl/ser_ctl_decode.sv
module ser_ctl_decode
  import ser_ctl_pkg::*;
(
  input  word_a_t           wa,
  input  word_b_t           wb,
  output logic [6:0]        main_ratio,
  output logic [4:0]        swallow,
  output logic [11:0]       div_total,
  output logic              phase_norm,
  output logic [1:0]        pa_code,
  output logic signed [5:0] pa_dbm,
  output logic              gf_en,
  output logic              mcc_en,
  output logic [7:0]        gf_gain_pct,
  output logic [3:0]        vco_trim,
  output logic [1:0]        cp_code,
  output logic [7:0]        cp_pct,
  output logic [4:0]        demod_trim,
  output logic [7:0]        mcc_gain_pct,
  output logic [2:0]        test_sel,
  output logic              cp_hiz
);

  always_comb begin
    main_ratio   = 7'd64 + {3'd0, wa.mc};
    swallow      = wa.sc;
    div_total    = {main_ratio, 5'd0} + {7'd0, wa.sc};
    phase_norm   = wa.ps;
    pa_code      = wa.pa;
    pa_dbm       = pa_dbm_of(wa.pa);
    gf_en        = wa.gf_en;
    mcc_en       = wa.mcc_en;
    gf_gain_pct  = gain_pct(wa.gf_gain);
    vco_trim     = wa.vco;
    cp_code      = wa.cp;
    cp_pct       = cp_pct_of(wa.cp);
    demod_trim   = wb.demod;
    mcc_gain_pct = gain_pct(wb.mcc_gain);
    test_sel     = wb.test;
    cp_hiz       = wb.test[2] & ~(wb.test[1] & wb.test[0]);
  end

endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_clk,
  input  logic        bus_dat,
  input  logic        bus_en_n,
  output logic [6:0]  main_ratio,
  output logic [4:0]  swallow,
  output logic [11:0] div_total,
  output logic        phase_norm,
  output logic [1:0]  pa_code,
  output logic [5:0]  pa_dbm,
  output logic        gf_en,
  output logic        mcc_en,
  output logic [7:0]  gf_gain_pct,
  output logic [3:0]  vco_trim,
  output logic [1:0]  cp_code,
  output logic [7:0]  cp_pct,
  output logic [4:0]  demod_trim,
  output logic [7:0]  mcc_gain_pct,
  output logic [2:0]  test_sel,
  output logic        cp_hiz,
  output logic        w1_load,
  output logic        w2_load
);

  logic [2:0]      s_bus;
  logic [SR_W-1:0] sreg;
  logic            commit;
  word_a_t         wa;
  word_b_t         wb;

  ser_ctl_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_en_n, bus_dat, bus_clk}),
    .q     (s_bus)
  );

  ser_ctl_shifter #(.W(SR_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_clk  (s_bus[0]),
    .s_dat  (s_bus[1]),
    .s_en_n (s_bus[2]),
    .sreg   (sreg),
    .commit (commit)
  );

  ser_ctl_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .sreg   (sreg),
    .wa     (wa),
    .wb     (wb),
    .wa_ld  (w1_load),
    .wb_ld  (w2_load)
  );

  ser_ctl_decode u_dec (
    .wa           (wa),
    .wb           (wb),
    .main_ratio   (main_ratio),
    .swallow      (swallow),
    .div_total    (div_total),
    .phase_norm   (phase_norm),
    .pa_code      (pa_code),
    .pa_dbm       (pa_dbm),
    .gf_en        (gf_en),
    .mcc_en       (mcc_en),
    .gf_gain_pct  (gf_gain_pct),
    .vco_trim     (vco_trim),
    .cp_code      (cp_code),
    .cp_pct       (cp_pct),
    .demod_trim   (demod_trim),
    .mcc_gain_pct (mcc_gain_pct),
    .test_sel     (test_sel),
    .cp_hiz       (cp_hiz)
  );

  AST_COMMIT_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> $onehot({w1_load, w2_load})); // R11

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    div_total >= {main_ratio, 5'd0}); // R6

endmodule

// File: tb/test_ser_ctl_port.sv
module test_ser_ctl_port;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0;
  logic bus_dat = 1'b0;
  logic bus_en_n = 1'b1;

  logic [6:0]  main_ratio;
  logic [4:0]  swallow;
  logic [11:0] div_total;
  logic        phase_norm;
  logic [1:0]  pa_code;
  logic [5:0]  pa_dbm;
  logic        gf_en, mcc_en;
  logic [7:0]  gf_gain_pct;
  logic [3:0]  vco_trim;
  logic [1:0]  cp_code;
  logic [7:0]  cp_pct;
  logic [4:0]  demod_trim;
  logic [7:0]  mcc_gain_pct;
  logic [2:0]  test_sel;
  logic        cp_hiz, w1_load, w2_load;

  always #10 clk = ~clk;

  ser_ctl_port i_ser_ctl_port (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .bus_en_n(bus_en_n), .main_ratio(main_ratio), .swallow(swallow),
    .div_total(div_total), .phase_norm(phase_norm), .pa_code(pa_code),
    .pa_dbm(pa_dbm), .gf_en(gf_en), .mcc_en(mcc_en),
    .gf_gain_pct(gf_gain_pct), .vco_trim(vco_trim), .cp_code(cp_code),
    .cp_pct(cp_pct), .demod_trim(demod_trim), .mcc_gain_pct(mcc_gain_pct),
    .test_sel(test_sel), .cp_hiz(cp_hiz), .w1_load(w1_load),
    .w2_load(w2_load)
  );

  int n_run = 0;
  int n_fail = 0;
  int cnt1 = 0, cnt2 = 0, exp1 = 0, exp2 = 0;
  int hi1 = 0, hi2 = 0;
  bit done = 1'b0;

  logic [23:0] shadow = 24'd0;
  // reset contents, field order per R4 / R5
  logic [22:0] ew1 = {4'd12, 5'd19, 1'b1, 2'd3, 1'b1, 1'b1, 3'd4, 4'd8, 2'd0};
  logic [10:0] ew2 = {5'd16, 3'd4, 3'd0};

  // last bit is the address
  localparam logic [23:0] VEC [8] = '{
    24'b0000_00000_0_00_0_0_000_0000_00_1,
    24'b1111_11111_1_11_1_1_111_1111_11_1,
    24'b0101_00001_0_01_1_0_010_0011_10_1,
    24'b1010_10000_1_10_0_1_101_1100_01_1,
    24'b1010_1010_1010_11111_000_000_0,
    24'b0000_0000_0000_00000_111_110_0,
    24'b1111_1111_1111_01010_011_101_0,
    24'b0110_00111_0_00_1_1_110_0110_11_1
  };

  always @(negedge clk) begin
    if (w1_load) begin cnt1++; hi1++; end else hi1 = 0;
    if (w2_load) begin cnt2++; hi2++; end else hi2 = 0;
    if (hi1 > 1 || hi2 > 1 || (w1_load && w2_load)) begin
      n_run++; n_fail++;
      $display("FAIL R11 strobe width/overlap act w1=%0b w2=%0b exp single one-cycle pulse",
               w1_load, w2_load);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int e_cp(input logic [1:0] c);
    case (c) 2'd2: return 80; 2'd3: return 90; 2'd0: return 100; default: return 110; endcase
  endfunction

  function automatic int e_pa(input logic [1:0] c);
    case (c) 2'd0: return -17; 2'd1: return -7; 2'd2: return -1; default: return 3; endcase
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " R4 R6 main_ratio"}, main_ratio, 64 + ew1[22:19]);
    chk({tag, " R4 swallow"}, swallow, ew1[18:14]);
    chk({tag, " R6 div_total"}, div_total, 32 * (64 + ew1[22:19]) + ew1[18:14]);
    chk({tag, " R4 phase"}, phase_norm, ew1[13]);
    chk({tag, " R4 pa_code"}, pa_code, ew1[12:11]);
    chk({tag, " R7 pa_dbm"}, $signed(pa_dbm), e_pa(ew1[12:11]));
    chk({tag, " R4 gf_en"}, gf_en, ew1[10]);
    chk({tag, " R4 mcc_en"}, mcc_en, ew1[9]);
    chk({tag, " R8 gf_gain_pct"}, gf_gain_pct, 60 + 10 * ew1[8:6]);
    chk({tag, " R4 vco_trim"}, vco_trim, ew1[5:2]);
    chk({tag, " R4 cp_code"}, cp_code, ew1[1:0]);
    chk({tag, " R7 cp_pct"}, cp_pct, e_cp(ew1[1:0]));
    chk({tag, " R5 demod_trim"}, demod_trim, ew2[10:6]);
    chk({tag, " R8 mcc_gain_pct"}, mcc_gain_pct, 60 + 10 * ew2[5:3]);
    chk({tag, " R5 test_sel"}, test_sel, ew2[2:0]);
    chk({tag, " R9 cp_hiz"}, cp_hiz, (ew2[2:0] >= 3'd4 && ew2[2:0] <= 3'd6) ? 1 : 0);
    chk({tag, " R2 R11 w1 strobe count"}, cnt1, exp1);
    chk({tag, " R2 R11 w2 strobe count"}, cnt2, exp2);
  endtask

  task automatic clk_pulse(input logic b, input bit track);
    bus_dat = b;
    repeat (2) @(negedge clk);
    bus_clk = 1'b1;
    if (track) shadow = {shadow[22:0], b};
    repeat (4) @(negedge clk);
    bus_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [63:0] bits, input int n);
    bus_en_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) clk_pulse(bits[i], 1'b1);
    bus_en_n = 1'b1;
    if (shadow[0]) begin ew1 = shadow[23:1]; exp1++; end
    else           begin ew2 = shadow[11:1]; exp2++; end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("reset R10");

    for (int v = 0; v < 8; v++) begin
      xfer({40'd0, VEC[v]}, 24);
      check_all("vector R1 R2");
    end

    // R3: 30-bit transfer, six leading ones fall off
    xfer({34'd0, 6'b111111, 24'b0011_00101_1_01_0_1_011_0101_10_1}, 30);
    check_all("long R3");

    // R1: clock edges with enable high are ignored; re-commit with no clocks
    xfer({40'd0, 24'b0000_0000_0000_10101_010_011_0}, 24);
    for (int k = 0; k < 3; k++) clk_pulse(1'b1, 1'b0);
    xfer(64'd0, 0);
    check_all("enable-high R1");

    // R12: short 12-bit transfer into word B
    xfer({52'd0, 12'b01110_001_101_0}, 12);
    check_all("short R12");

    // R12: short 8-bit transfer reaches word A via old contents
    xfer({56'd0, 8'b0110_0111}, 8);
    check_all("short-a R12");

    // R9: sweep test codes
    for (int t = 0; t < 8; t++) begin
      xfer({52'd0, 5'd3, 3'd2, t[2:0], 1'b0}, 12);
      check_all("test-sweep R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule